// File: doc/BRIEF.md
# Sleep and Wake Mode Controller

This block decides whether a motor-driver support chip is awake or asleep. It runs on a fixed internal oscillator clock and samples four digital inputs: a low-voltage enable line from the host controller, a high-voltage wake line, the receive line of a LIN bus, and a watchdog select level. The block wakes up in Active mode after power-on reset. A deliberate falling edge on the enable line, held low long enough, puts it to Sleep. It returns to Active when the wake line shows a debounced rising edge, or when the bus carries a remote wake pattern: a falling edge, a dominant level held long enough, and then a release.

The outputs drive the enables of the logic supply regulator, the battery pass switch, the LIN slave termination and the watchdog. There is also a ready flag, which is raised only after a fixed regulator start-up allowance. The analog parts are outside this block: comparators, regulators and the bus transceiver. Every time window is a tick count set by a parameter.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset the mode is Active (`asleep_o`=0), and the supply, switch and termination enables are 1.
- R2: Sleep is entered at the HOLD_TICKS-th consecutive clock at which `en_lv_i` is sampled low, counted from the first low sample that follows a high sample.
- R3: A low on `en_lv_i` that lasts fewer than HOLD_TICKS samples causes no sleep. A level that is already low when Active begins causes no sleep.
- R4: In Sleep, the controller wakes when `wake_hv_i` has differed from its last accepted level for DEB_TICKS consecutive samples and the newly accepted level is 1. A pulse that is shorter than this is ignored.
- R5: In Sleep, the controller wakes at the first high sample of `lin_rx_i` that follows at least DOM_TICKS consecutive low samples, where that low run itself began with a high-to-low change seen in Sleep.
- R6: A dominant (low) run on `lin_rx_i` that is shorter than DOM_TICKS causes no wake. A bus held low causes no wake for as long as it stays low.
- R7: `vcc_en_o`, `batsw_en_o` and `lin_term_en_o` are 1 in Active and 0 in Sleep. `batsw_en_o` changes only on a mode transition.
- R8: `wdog_en_o` equals `wd_sel_i` in Active and is 0 in Sleep.
- R9: `active_ready_o` is 0 in Sleep. It rises START_TICKS clocks after reset release or after a wake.
- R10: In Active, `wake_hv_i` and `lin_rx_i` have no effect on the mode. In Sleep, `en_lv_i` has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Power-on reset, active low |
| en_lv_i | input | 1 | Low-voltage enable from host; a held falling edge requests sleep |
| wake_hv_i | input | 1 | High-voltage wake line; debounced rising edge wakes |
| lin_rx_i | input | 1 | LIN receive level, 1 = recessive |
| wd_sel_i | input | 1 | Watchdog select level |
| vcc_en_o | output | 1 | Logic supply regulator enable |
| batsw_en_o | output | 1 | Battery pass-switch enable |
| lin_term_en_o | output | 1 | LIN slave termination enable |
| wdog_en_o | output | 1 | Watchdog enable |
| active_ready_o | output | 1 | Active mode after start-up allowance |
| asleep_o | output | 1 | 1 while in Sleep |

## Verification
The enable line is driven with three patterns: a short low dip, a long held low that follows a high, and a low level that persists across a wake. Together these separate edge qualification from a plain level trigger. The bus line is driven with a short dominant pulse, a long pulse that ends in a release, and a line stuck low. These show that the wake is taken at the release, and only after the dominant time has been met. The wake line is driven with a glitch and with a held level, which exercises the debouncer. The same wake stimuli are then repeated in Active, and the enable line is toggled in Sleep, to confirm that each input is ignored in the mode where it has no role.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int HOLD_TICKS  = 8,
  parameter int DOM_TICKS   = 20,
  parameter int DEB_TICKS   = 5,
  parameter int START_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_lv_i,
  input  logic wake_hv_i,
  input  logic lin_rx_i,
  input  logic wd_sel_i,
  output logic vcc_en_o,
  output logic batsw_en_o,
  output logic lin_term_en_o,
  output logic wdog_en_o,
  output logic active_ready_o,
  output logic asleep_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int DW = $clog2(DOM_TICKS + 1);
  localparam int BW = $clog2(DEB_TICKS + 1);
  localparam int SW = $clog2(START_TICKS + 1);

  typedef enum logic {ACTIVE = 1'b0, SLEEP = 1'b1} mode_t;

  mode_t          mode;
  logic           ready;
  logic           en_prev, rx_prev, hv_stab, dom_armed;
  logic [HW-1:0]  hold_cnt;
  logic [DW-1:0]  dom_cnt;
  logic [BW-1:0]  deb_cnt;
  logic [SW-1:0]  st_cnt;

  wire is_active = (mode == ACTIVE);

  wire          en_fall   = en_prev & ~en_lv_i;
  wire          hold_live = ~en_lv_i & (en_fall | (hold_cnt != '0));
  wire [HW-1:0] hold_nxt  = en_fall ? HW'(1) : hold_cnt + HW'(1);
  wire          go_sleep  = is_active & hold_live & (hold_nxt == HW'(HOLD_TICKS));

  wire hv_diff  = wake_hv_i ^ hv_stab;
  wire deb_done = hv_diff & (deb_cnt == BW'(DEB_TICKS - 1));
  wire hv_wake  = ~is_active & deb_done & wake_hv_i;

  wire rx_fall  = rx_prev & ~lin_rx_i;
  wire lin_wake = ~is_active & dom_armed & lin_rx_i & (dom_cnt == DW'(DOM_TICKS));

  wire wake = hv_wake | lin_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev <= 1'b0;
      rx_prev <= 1'b1;
    end else begin
      en_prev <= en_lv_i;
      rx_prev <= lin_rx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (!is_active || !hold_live || go_sleep)
      hold_cnt <= '0;
    else
      hold_cnt <= hold_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_stab <= 1'b0;
      deb_cnt <= '0;
    end else if (deb_done) begin
      hv_stab <= wake_hv_i;
      deb_cnt <= '0;
    end else if (hv_diff) begin
      deb_cnt <= deb_cnt + BW'(1);
    end else begin
      deb_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_armed <= 1'b0;
      dom_cnt   <= '0;
    end else if (is_active || lin_rx_i) begin
      dom_armed <= 1'b0;
      dom_cnt   <= '0;
    end else if (rx_fall) begin
      dom_armed <= 1'b1;
      dom_cnt   <= DW'(1);
    end else if (dom_armed && dom_cnt != DW'(DOM_TICKS)) begin
      dom_cnt   <= dom_cnt + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= ACTIVE;
      ready  <= 1'b0;
      st_cnt <= '0;
    end else if (go_sleep) begin
      mode   <= SLEEP;
      ready  <= 1'b0;
      st_cnt <= '0;
    end else if (wake) begin
      mode   <= ACTIVE;
      ready  <= 1'b0;
      st_cnt <= '0;
    end else if (is_active && !ready) begin
      if (st_cnt == SW'(START_TICKS - 1))
        ready <= 1'b1;
      else
        st_cnt <= st_cnt + SW'(1);
    end
  end

  assign vcc_en_o       = is_active;
  assign batsw_en_o     = is_active;
  assign lin_term_en_o  = is_active;
  assign wdog_en_o      = is_active & wd_sel_i;
  assign active_ready_o = ready;
  assign asleep_o       = ~is_active;
endmodule

module sleep_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic en_lv_i,
  input logic wake_hv_i,
  input logic lin_rx_i,
  input logic wd_sel_i,
  input logic vcc_en_o,
  input logic batsw_en_o,
  input logic lin_term_en_o,
  input logic wdog_en_o,
  input logic active_ready_o,
  input logic asleep_o
);
  p_sleep_rails_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_o |-> (!vcc_en_o && !batsw_en_o && !lin_term_en_o));

  p_switch_only_on_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(asleep_o) |-> $stable(batsw_en_o));

  p_wdog_off_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_o |-> !wdog_en_o);

  p_not_ready_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_o |-> !active_ready_o);

  p_wake_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_o) |-> !active_ready_o);

  p_sleep_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> $past(!en_lv_i));

  p_lin_stuck_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(asleep_o) && $past(!wake_hv_i)) |-> $past(lin_rx_i));
endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk u_chk (.*);

// File: tb/sleep_wake_ctrl_test.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_test;
  localparam int HOLD = 8, DOM = 20, DEB = 5, START = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_lv = 1'b1, wake_hv = 1'b0, lin_rx = 1'b1, wd_sel = 1'b1;
  logic vcc_en, batsw_en, lin_term_en, wdog_en, ready, asleep;

  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.HOLD_TICKS(HOLD), .DOM_TICKS(DOM), .DEB_TICKS(DEB), .START_TICKS(START)) uut (
    .clk(clk), .rst_n(rst_n), .en_lv_i(en_lv), .wake_hv_i(wake_hv), .lin_rx_i(lin_rx),
    .wd_sel_i(wd_sel), .vcc_en_o(vcc_en), .batsw_en_o(batsw_en), .lin_term_en_o(lin_term_en),
    .wdog_en_o(wdog_en), .active_ready_o(ready), .asleep_o(asleep));

  bit m_act, m_rdy, m_enp, m_rxp, m_hv;
  int m_sc, m_enl, m_hvr, m_rxl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 1; m_rdy = 0; m_sc = 0; m_enp = 0; m_rxp = 1; m_hv = 0;
      m_enl = 0; m_hvr = 0; m_rxl = 0;
    end else begin
      bit go, wk;
      go = 0; wk = 0;
      if (m_act) begin
        if (!en_lv && m_enp) m_enl = 1;
        else if (!en_lv && m_enl > 0) m_enl++;
        else m_enl = 0;
        if (m_enl == HOLD) begin go = 1; m_enl = 0; end
      end else m_enl = 0;
      if (wake_hv != m_hv) begin
        m_hvr++;
        if (m_hvr == DEB) begin
          m_hv = wake_hv; m_hvr = 0;
          if (wake_hv && !m_act) wk = 1;
        end
      end else m_hvr = 0;
      if (!m_act) begin
        if (!lin_rx && m_rxp) m_rxl = 1;
        else if (!lin_rx && m_rxl > 0) m_rxl++;
        else begin
          if (lin_rx && m_rxl >= DOM) wk = 1;
          m_rxl = 0;
        end
      end else m_rxl = 0;
      m_enp = en_lv; m_rxp = lin_rx;
      if (go) begin m_act = 0; m_rdy = 0; m_sc = 0; end
      else if (wk) begin m_act = 1; m_rdy = 0; m_sc = 0; end
      else if (m_act && !m_rdy) begin m_sc++; if (m_sc == START) m_rdy = 1; end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 asleep", asleep, !m_act);
      chk("R7 vcc_en", vcc_en, m_act);
      chk("R7 batsw_en", batsw_en, m_act);
      chk("R7 lin_term_en", lin_term_en, m_act);
      chk("R8 wdog_en", wdog_en, m_act & wd_sel);
      chk("R9 ready", ready, m_rdy);
    end
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R1 watchdog expired: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_sleep();
    en_lv = 1'b1; tick(3);
    en_lv = 1'b0; tick(HOLD + 2);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset active", asleep, 1'b0);
    chk("R1 reset vcc", vcc_en, 1'b1);
    tick(START + 1);
    chk("R9 ready after start", ready, 1'b1);

    en_lv = 1'b0; tick(HOLD - 2); en_lv = 1'b1; tick(4);
    chk("R3 short dip no sleep", asleep, 1'b0);

    en_lv = 1'b0; tick(HOLD + 1);
    chk("R2 held fall sleeps", asleep, 1'b1);
    chk("R7 switch off in sleep", batsw_en, 1'b0);
    chk("R8 wdog off in sleep", wdog_en, 1'b0);

    en_lv = 1'b1; tick(4); en_lv = 1'b0; tick(HOLD + 4);
    chk("R10 en ignored in sleep", asleep, 1'b1);

    lin_rx = 1'b0; tick(DOM - 5); lin_rx = 1'b1; tick(4);
    chk("R6 short dominant no wake", asleep, 1'b1);

    lin_rx = 1'b0; tick(DOM + 5);
    chk("R5 no wake before release", asleep, 1'b1);
    lin_rx = 1'b1; tick(2);
    chk("R5 wake on release", asleep, 1'b0);
    chk("R5 termination on", lin_term_en, 1'b1);
    tick(HOLD + 10);
    chk("R3 low level no re-sleep", asleep, 1'b0);
    wd_sel = 1'b0; tick(1);
    chk("R8 wdog follows select", wdog_en, 1'b0);
    wd_sel = 1'b1;

    wake_hv = 1'b1; tick(DEB + 3); wake_hv = 1'b0; tick(DEB + 3);
    lin_rx = 1'b0; tick(DOM + 3); lin_rx = 1'b1; tick(3);
    chk("R10 wakes ignored in active", asleep, 1'b0);

    enter_sleep();
    chk("R2 sleep again", asleep, 1'b1);
    wake_hv = 1'b1; tick(DEB - 2); wake_hv = 1'b0; tick(DEB + 2);
    chk("R4 glitch ignored", asleep, 1'b1);
    wake_hv = 1'b1; tick(DEB + 2);
    chk("R4 debounced wake", asleep, 1'b0);
    tick(START + 1);
    chk("R9 ready after wake", ready, 1'b1);
    wake_hv = 1'b0; tick(DEB + 2);

    enter_sleep();
    lin_rx = 1'b0; tick(5 * DOM);
    chk("R6 stuck dominant no wake", asleep, 1'b1);
    lin_rx = 1'b1; tick(2);
    chk("R5 wake after long dominant", asleep, 1'b0);
    tick(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule